// File: doc/BRIEF.md
# Oversampling Conversion Sequencer

This block runs one conversion cycle of an eight-channel simultaneous-sampling converter. Two convert-start strobes each mark the hold instant for one half of the channels: the first strobe covers channels 0 to 3 and the second covers channels 4 to 7. The conversion starts only once both strobes have produced a rising edge. From then on, `busy` is high. The block asks an external converter core for one sample at a time over a request/valid handshake. It walks the channels in ascending order, once per oversampling pass.

With an oversampling ratio N, the block runs N passes. The first pass belongs to the strobe edge. The block triggers the remaining N−1 passes internally, with no further strobe. Each channel has a signed accumulator that sums its N samples. When the last sample arrives, every sum is divided by N with an arithmetic shift. The eight 18-bit results are then loaded into an output bank, and `busy` falls in the same clock cycle.

The oversampling select is sampled only at the falling edge of `busy`. The value sampled there sets the ratio of the next conversion. The bank holds the previous results for the whole time `busy` is high.

Top module: `os_conv_seq`

## Requirements
- R1: The ratio code decodes as 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, 6→64 passes. Each channel result is the twos-complement sum of its N 18-bit samples, divided by N and rounded toward negative infinity. Channel c appears on `res_flat[18c+17:18c]`.
- R2: Ratio code 7 is invalid and is used as ratio 1. Sampling code 7 at a `busy` falling edge sets `os_err`. `os_err` then stays set until reset.
- R3: `os_sel` is sampled at the clock edge where `busy` falls. The sampled value sets the ratio of the following conversion. The first conversion after reset uses ratio 1.
- R4: `busy` goes high in the cycle after the clock edge that sees the later of the two strobe rising edges, or both edges together. A rising edge on only one strobe does not raise `busy`.
- R5: A strobe rising edge that arrives while `busy` is high is ignored. It does not start a conversion after `busy` falls.
- R6: A conversion issues exactly 8×N sample requests. Channels are requested in the order 0,1,…,7 in every pass. At most one request is outstanding, and all eight channels are always converted.
- R7: `res_flat` changes only at the edge where `busy` falls. While `busy` is high, it shows the previous conversion's results.
- R8: After reset, `busy`, `os_err` and `smp_req` are 0 and every result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_a | input | 1 | Start strobe for channels 0–3 (rising edge) |
| conv_b | input | 1 | Start strobe for channels 4–7 (rising edge) |
| os_sel | input | 3 | Oversampling ratio code |
| busy | output | 1 | Conversion in progress |
| os_err | output | 1 | Sticky flag: invalid ratio code was sampled |
| smp_req | output | 1 | One-cycle request for one sample from the core |
| smp_chan | output | 3 | Channel index of the current request |
| smp_valid | input | 1 | Core returns the requested sample |
| smp_data | input | 18 | Twos-complement sample from the core |
| res_flat | output | 144 | Averaged result bank, 18 bits per channel |

## Verification
The bench aims at the cases where timing or rounding is easy to get wrong.

- **Strobe skew.** A design that started on the first edge alone would raise `busy` before the second strobe arrives.
- **Late ratio change.** `os_sel` changes during a conversion. A design that sampled it at the start would issue the wrong number of requests.
- **Invalid code.** A design that did not treat code 7 as ratio 1 would request a different number of samples. A design that did not keep `os_err` set would report a missing error.
- **Accumulator extremes.** Full-scale positive and negative inputs at ratio 64 expose a narrow or unsigned accumulator.
- **Negative rounding.** The sum −1 at ratio 2 must give −1. A design that rounds toward zero would give 0.
- **Strobes during `busy`.** Strobes pulsed while `busy` is high would show up as an extra conversion if they were latched.

// File: rtl/os_seq_pkg.sv
package os_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_DONE  = 2'd3
   } sq_state_t;

   localparam int unsigned OS_CODE_W   = 3;
   localparam logic [OS_CODE_W-1:0] OS_CODE_BAD = 3'b111;

   // Invalid ratio code falls back to "no oversampling"
   function automatic logic [OS_CODE_W-1:0] os_sanitize(input logic [OS_CODE_W-1:0] code);
      return (code == OS_CODE_BAD) ? '0 : code;
   endfunction

endpackage

// File: rtl/os_start_sync.sv
module os_start_sync #(
   parameter int unsigned GRP = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [GRP-1:0] conv,
   input  logic           idle,
   output logic           go
);

   logic [GRP-1:0] conv_q;
   logic [GRP-1:0] held;
   logic [GRP-1:0] rise;

   assign rise = conv & ~conv_q;
   assign go   = idle & (&(held | rise));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conv_q <= '0;
         held   <= '0;
      end else begin
         conv_q <= conv;
         if (go) begin
            held <= '0;
         end else if (idle) begin
            held <= held | rise;
         end
      end
   end

   AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (held == '0));   // R5

   AST_NO_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && held == '0) |=> (held == '0));   // R5

endmodule

// File: rtl/os_seq_ctrl.sv
module os_seq_ctrl
   import os_seq_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned MAX_LOG = 6,
   localparam int unsigned CH_W   = $clog2(NUM_CH),
   localparam int unsigned PW     = MAX_LOG
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [OS_CODE_W-1:0] os_sel,
   input  logic                 smp_valid,
   output logic                 busy,
   output logic                 idle,
   output logic                 smp_req,
   output logic [CH_W-1:0]      smp_chan,
   output logic                 acc_en,
   output logic                 load,
   output logic [OS_CODE_W-1:0] ratio_code,
   output logic                 os_err
);

   sq_state_t       state;
   logic [CH_W-1:0] chan_cnt;
   logic [PW-1:0]   pass_cnt;
   logic [PW:0]     pass_lim;
   logic            chan_last;
   logic            pass_last;

   assign pass_lim  = ({{PW{1'b0}}, 1'b1} << ratio_code) - 1'b1;
   assign pass_last = ({1'b0, pass_cnt} == pass_lim);
   assign chan_last = (chan_cnt == CH_W'(NUM_CH - 1));

   assign idle     = (state == SQ_IDLE);
   assign busy     = !idle;
   assign smp_req  = (state == SQ_ISSUE);
   assign smp_chan = chan_cnt;
   assign acc_en   = (state == SQ_WAIT) && smp_valid;
   assign load     = (state == SQ_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         chan_cnt   <= '0;
         pass_cnt   <= '0;
         ratio_code <= '0;
         os_err     <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (go) begin
                  state    <= SQ_ISSUE;
                  chan_cnt <= '0;
                  pass_cnt <= '0;
               end
            end
            SQ_ISSUE: state <= SQ_WAIT;
            SQ_WAIT: begin
               if (smp_valid) begin
                  if (chan_last) begin
                     chan_cnt <= '0;
                     if (pass_last) begin
                        state <= SQ_DONE;
                     end else begin
                        pass_cnt <= pass_cnt + 1'b1;
                        state    <= SQ_ISSUE;
                     end
                  end else begin
                     chan_cnt <= chan_cnt + 1'b1;
                     state    <= SQ_ISSUE;
                  end
               end
            end
            SQ_DONE: begin
               state      <= SQ_IDLE;
               ratio_code <= os_sanitize(os_sel);
               if (os_sel == OS_CODE_BAD) os_err <= 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(os_err) |-> os_err);   // R2

   AST_RATIO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ratio_code));   // R3

   AST_START_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go));   // R4

   AST_FIRST_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (smp_req && smp_chan == '0));   // R6

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      smp_req |=> !smp_req);   // R6

endmodule

// File: rtl/os_acc_bank.sv
module os_acc_bank #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DATA_W = 18,
   parameter int unsigned ACC_W  = 24,
   parameter int unsigned SH_W   = 3,
   localparam int unsigned CH_W  = $clog2(NUM_CH),
   localparam int unsigned EXT_W = ACC_W - DATA_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_clr,
   input  logic                     acc_en,
   input  logic [CH_W-1:0]          acc_chan,
   input  logic [DATA_W-1:0]        smp_data,
   input  logic [SH_W-1:0]          shift,
   input  logic                     load,
   output logic [NUM_CH*DATA_W-1:0] res_flat
);

   logic signed [ACC_W-1:0] smp_ext;
   assign smp_ext = {{EXT_W{smp_data[DATA_W-1]}}, smp_data};

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic signed [ACC_W-1:0]  acc;
      logic signed [ACC_W-1:0]  avg;
      logic        [DATA_W-1:0] result;
      logic        [ACC_W:0]    wide_sum;
      logic                     hit;

      assign hit      = acc_en && (acc_chan == CH_W'(g));
      assign avg      = acc >>> shift;
      assign wide_sum = {acc[ACC_W-1], acc} + {smp_ext[ACC_W-1], smp_ext};

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc    <= '0;
            result <= '0;
         end else begin
            if (acc_clr) begin
               acc <= '0;
            end else if (hit) begin
               acc <= acc + smp_ext;
            end
            if (load) result <= avg[DATA_W-1:0];
         end
      end

      assign res_flat[g*DATA_W +: DATA_W] = result;

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));   // R1
   end

endmodule

// File: rtl/os_conv_seq.sv
module os_conv_seq
   import os_seq_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned DATA_W  = 18,
   parameter int unsigned MAX_LOG = 6,
   localparam int unsigned ACC_W  = DATA_W + MAX_LOG,
   localparam int unsigned CH_W   = $clog2(NUM_CH),
   localparam int unsigned RES_W  = NUM_CH * DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 conv_a,
   input  logic                 conv_b,
   input  logic [OS_CODE_W-1:0] os_sel,
   output logic                 busy,
   output logic                 os_err,
   output logic                 smp_req,
   output logic [CH_W-1:0]      smp_chan,
   input  logic                 smp_valid,
   input  logic [DATA_W-1:0]    smp_data,
   output logic [RES_W-1:0]     res_flat
);

   if (NUM_CH < 2 || (NUM_CH % 2) != 0) begin : g_bad_ch
      $error("NUM_CH must be even and at least 2");
   end
   if (MAX_LOG < 6) begin : g_bad_log
      $error("MAX_LOG must cover ratio code 6");
   end
   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W too small");
   end

   logic                 go;
   logic                 idle;
   logic                 acc_en;
   logic                 load;
   logic [OS_CODE_W-1:0] ratio_code;

   os_start_sync #(.GRP(2)) u_start (
      .clk   (clk),
      .rst_n (rst_n),
      .conv  ({conv_b, conv_a}),
      .idle  (idle),
      .go    (go)
   );

   os_seq_ctrl #(.NUM_CH(NUM_CH), .MAX_LOG(MAX_LOG)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .os_sel     (os_sel),
      .smp_valid  (smp_valid),
      .busy       (busy),
      .idle       (idle),
      .smp_req    (smp_req),
      .smp_chan   (smp_chan),
      .acc_en     (acc_en),
      .load       (load),
      .ratio_code (ratio_code),
      .os_err     (os_err)
   );

   os_acc_bank #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .SH_W   (OS_CODE_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_clr  (go),
      .acc_en   (acc_en),
      .acc_chan (smp_chan),
      .smp_data (smp_data),
      .shift    (ratio_code),
      .load     (load),
      .res_flat (res_flat)
   );

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(res_flat));   // R7

   AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      smp_req |-> busy);   // R6

endmodule

// File: tb/os_conv_seq_tb.sv
module os_conv_seq_tb;

   localparam int CORE_LAT = 3;
   localparam int NCH      = 8;
   localparam int DW       = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_a = 1'b0;
   logic          conv_b = 1'b0;
   logic [2:0]    os_sel = 3'd0;
   logic          busy;
   logic          os_err;
   logic          smp_req;
   logic [2:0]    smp_chan;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic [NCH*DW-1:0] res_flat;

   always #10 clk = ~clk;

   os_conv_seq u_dut (
      .clk(clk), .rst_n(rst_n), .conv_a(conv_a), .conv_b(conv_b),
      .os_sel(os_sel), .busy(busy), .os_err(os_err),
      .smp_req(smp_req), .smp_chan(smp_chan),
      .smp_valid(smp_valid), .smp_data(smp_data), .res_flat(res_flat)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int smp_tab [0:511];
   int kidx = 0;
   int order_err = 0;
   int lat_cnt = 0;
   int prev_exp [0:NCH-1];
   int cur_exp [0:NCH-1];

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int fdiv(input int s, input int n);
      if (s >= 0) return s / n;
      return -((-s + n - 1) / n);
   endfunction

   function automatic int res_ch(input int c);
      logic signed [DW-1:0] v;
      v = res_flat[c*DW +: DW];
      return int'(v);
   endfunction

   // Converter core model: one reply per request after CORE_LAT cycles
   initial begin
      forever begin
         @(negedge clk);
         smp_valid = 1'b0;
         if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
               smp_valid = 1'b1;
               smp_data  = DW'(smp_tab[kidx]);
               kidx++;
            end
         end else if (smp_req) begin
            if (int'(smp_chan) != (kidx % NCH)) order_err++;
            lat_cnt = CORE_LAT;
         end
      end
   end

   task automatic run_conv(input int cur_code, input int next_os, input bit skew,
                           input int mode, inout bit err_exp);
      int n;
      int wait_cyc;
      n = 1 << cur_code;
      for (int i = 0; i < 512; i++) begin
         case (mode)
            1: smp_tab[i] = 131071;
            2: smp_tab[i] = -131072;
            3: smp_tab[i] = ((i / NCH) == 0) ? -1 : 0;
            default: smp_tab[i] = int'($urandom % 262144) - 131072;
         endcase
      end
      kidx = 0;
      order_err = 0;
      @(negedge clk);
      if (skew) begin
         conv_a = 1'b1;
         repeat (3) begin
            @(negedge clk);
            check(busy == 1'b0, "R4 busy low before second strobe", busy, 0);
         end
         conv_b = 1'b1;
      end else begin
         conv_a = 1'b1;
         conv_b = 1'b1;
      end
      @(negedge clk);
      check(busy == 1'b1, "R4 busy after later strobe edge", busy, 1);
      os_sel = 3'(next_os);
      // strobe edges during busy must be ignored (R5)
      conv_a = 1'b0; conv_b = 1'b0;
      @(negedge clk);
      conv_a = 1'b1; conv_b = 1'b1;
      @(negedge clk);
      conv_a = 1'b0; conv_b = 1'b0;
      for (int c = 0; c < NCH; c++)
         check(res_ch(c) == prev_exp[c], "R7 bank holds old result during busy", res_ch(c), prev_exp[c]);
      wait_cyc = 0;
      while (busy && wait_cyc < 20000) begin
         @(negedge clk);
         wait_cyc++;
      end
      for (int c = 0; c < NCH; c++) begin
         int s;
         s = 0;
         for (int p = 0; p < n; p++) s += smp_tab[p*NCH + c];
         cur_exp[c] = fdiv(s, n);
         check(res_ch(c) == cur_exp[c], "R1 averaged channel result", res_ch(c), cur_exp[c]);
      end
      check(kidx == NCH * n, "R3 R6 request count follows latched ratio", kidx, NCH * n);
      check(order_err == 0, "R6 channel request order", order_err, 0);
      repeat (5) @(negedge clk);
      check(busy == 1'b0 && kidx == NCH * n, "R5 no conversion from edges seen during busy",
            kidx, NCH * n);
      if (next_os == 7) err_exp = 1'b1;
      check(os_err == err_exp, "R2 sticky invalid-code flag", os_err, err_exp);
      for (int c = 0; c < NCH; c++) prev_exp[c] = cur_exp[c];
   endtask

   initial begin
      int codes [0:9];
      int modes [0:9];
      bit skews [0:9];
      int cur;
      bit err_exp;
      void'($urandom(32'd1234));
      codes = '{2, 0, 7, 6, 6, 1, 3, 4, 5, 0};
      modes = '{0, 0, 0, 0, 1, 2, 3, 0, 0, 0};
      skews = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 0};
      for (int c = 0; c < NCH; c++) prev_exp[c] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check(busy == 1'b0, "R8 busy after reset", busy, 0);
      check(os_err == 1'b0, "R8 os_err after reset", os_err, 0);
      check(smp_req == 1'b0, "R8 no request after reset", smp_req, 0);
      check(res_flat == '0, "R8 results zero after reset", (res_flat != '0), 0);
      // R4: single strobe edge only must not start
      conv_a = 1'b1;
      repeat (4) @(negedge clk);
      check(busy == 1'b0, "R4 one strobe alone does not start", busy, 0);
      conv_a = 1'b0;
      @(negedge clk);
      cur = 0;
      err_exp = 1'b0;
      for (int k = 0; k < 10; k++) begin
         run_conv(cur, codes[k], skews[k], modes[k], err_exp);
         cur = (codes[k] == 7) ? 0 : codes[k];
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule